// File: doc/BRIEF.md
# Data Cache Command and Status Register

This block is the software-facing control register of a data cache. Software never writes the cache mode bits directly. It writes a 4-bit command code into a command field, and the block decodes it. Status commands set or clear one of three mode bits: cache enable, forced write-through and little-endian byte swap. Maintenance commands send a one-cycle request to the cache. Each request carries the command code and a target address, which is sampled from a separate address input.

The block also holds a sticky copyback-error flag. The cache raises it when a flush or copyback fails. While the flag is set it drives a machine-check request. A register read clears the flag, unless a new error arrives in the same cycle. A busy input from the cache causes any command written while the cache is busy to be discarded.

Register bits are numbered from the most significant end, so bit 0 of the register is bus bit DATA_W-1.

Top module: `dcache_ctl_reg`

## Requirements
- R1: After reset the enable, write-through, swap and error flags are 0, `mchk_o` is 0 and `maint_valid_o` is 0.
- R2: Data written to register bits 0–2 (bus bits 31, 30, 29) has no direct effect. Only the decoded command field changes them.
- R3: Command 4'b0010 sets cache enable and command 4'b0100 clears it. The new value is visible on `cache_en_o` and `rdata_o[31]` one clock after the write.
- R4: Command 4'b0001 sets forced write-through and command 4'b0011 clears it. The value is visible on `force_wt_o` and `rdata_o[30]` one clock after the write.
- R5: Command 4'b0101 sets little-endian swap and command 4'b0111 clears it. The value is visible on `le_swap_o` and `rdata_o[29]` one clock after the write.
- R6: Each of the commands 4'b0110 (load and lock), 4'b1000 (unlock block), 4'b1010 (unlock all), 4'b1100 (invalidate all) and 4'b1110 (flush block) raises `maint_valid_o` for exactly one cycle, one clock after the write. During that cycle `maint_cmd_o` holds the code and `maint_addr_o` holds `addr_i` as sampled at the write.
- R7: Codes 4'b0000, 4'b1001, 4'b1011, 4'b1101 and 4'b1111 change no mode bit and raise no request.
- R8: `rdata_o` carries enable on bit 31, write-through on bit 30, swap on bit 29 and the error flag on bit 21. All other bits read 0, and the command field (bits 27:24) always reads 4'b0000.
- R9: A pulse on `err_set_i` sets the error flag on the next clock. The flag stays set until a cycle with `rd_en_i` high, and is clear after that clock. `mchk_o` equals the flag.
- R10: If `err_set_i` and `rd_en_i` are both high in the same cycle, the flag is 1 after that clock.
- R11: A write with `busy_i` high is discarded: no mode bit changes and no request is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wdata_i | input | DATA_W | Write data; command field on bits 27:24 |
| rd_en_i | input | 1 | Register read strobe; clears the error flag |
| rdata_o | output | DATA_W | Register read value |
| addr_i | input | ADDR_W | Target address for maintenance commands |
| busy_i | input | 1 | Cache busy; commands are discarded while high |
| err_set_i | input | 1 | Copyback failure report from the cache |
| cache_en_o | output | 1 | Cache enable mode bit |
| force_wt_o | output | 1 | Forced write-through mode bit |
| le_swap_o | output | 1 | Little-endian swap mode bit |
| maint_valid_o | output | 1 | One-cycle maintenance request |
| maint_cmd_o | output | 4 | Code of the requested maintenance command |
| maint_addr_o | output | ADDR_W | Address of the requested maintenance command |
| mchk_o | output | 1 | Machine-check request, high while the error flag is set |

## Verification
The assertions assume that the strobes and `err_set_i` are clean single-bit levels once reset is released. They also assume that `busy_i` is the only thing that holds off a command. No ordering is assumed between reads, writes and error reports, because the bench drives all of these in every combination, including a read and an error in the same cycle and back-to-back maintenance writes. Inputs change only at the falling clock edge, so every rising edge samples stable values. A behavioural model in the bench predicts every output cycle by cycle.

// File: rtl/dcc_pkg.sv
package dcc_pkg;
   localparam int CMD_W = 4;

   typedef enum logic [CMD_W-1:0] {
      CMD_RSV0       = 4'h0,
      CMD_WT_SET     = 4'h1,
      CMD_EN_SET     = 4'h2,
      CMD_WT_CLR     = 4'h3,
      CMD_EN_CLR     = 4'h4,
      CMD_LE_SET     = 4'h5,
      CMD_LOCK       = 4'h6,
      CMD_LE_CLR     = 4'h7,
      CMD_UNLOCK     = 4'h8,
      CMD_RSV9       = 4'h9,
      CMD_UNLOCK_ALL = 4'hA,
      CMD_RSVB       = 4'hB,
      CMD_INV_ALL    = 4'hC,
      CMD_RSVD       = 4'hD,
      CMD_FLUSH      = 4'hE,
      CMD_RSVF       = 4'hF
   } dcc_cmd_e;

   // index order of the three mode bits
   localparam int MODE_EN = 0;
   localparam int MODE_WT = 1;
   localparam int MODE_LE = 2;
   localparam int MODE_N  = 3;

   typedef struct packed {
      logic [MODE_N-1:0] set;
      logic [MODE_N-1:0] clr;
      logic              blk;
   } dcc_dec_t;

   // map a register bit number (0 = most significant) to a bus index
   function automatic int msb0(input int width, input int n);
      return width - 1 - n;
   endfunction
endpackage

// File: rtl/dcc_decode.sv
module dcc_decode
   import dcc_pkg::*;
(
   input  logic             cmd_vld_i,
   input  logic [CMD_W-1:0] cmd_i,
   output dcc_dec_t         dec_o
);
   always_comb begin
      dec_o = '0;
      if (cmd_vld_i) begin
         unique case (dcc_cmd_e'(cmd_i))
            CMD_EN_SET:     dec_o.set[MODE_EN] = 1'b1;
            CMD_EN_CLR:     dec_o.clr[MODE_EN] = 1'b1;
            CMD_WT_SET:     dec_o.set[MODE_WT] = 1'b1;
            CMD_WT_CLR:     dec_o.clr[MODE_WT] = 1'b1;
            CMD_LE_SET:     dec_o.set[MODE_LE] = 1'b1;
            CMD_LE_CLR:     dec_o.clr[MODE_LE] = 1'b1;
            CMD_LOCK, CMD_UNLOCK, CMD_UNLOCK_ALL,
            CMD_INV_ALL, CMD_FLUSH: dec_o.blk = 1'b1;
            default:        dec_o = '0;
         endcase
      end
   end

   always_comb begin
      a_r7_reserved_idle: assert (!(cmd_vld_i && cmd_i[0] && cmd_i[3]) || dec_o == '0);
   end
endmodule

// File: rtl/dcc_status.sv
module dcc_status
   import dcc_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [MODE_N-1:0] set_i,
   input  logic [MODE_N-1:0] clr_i,
   output logic [MODE_N-1:0] mode_o
);
   for (genvar g = 0; g < MODE_N; g++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        mode_o[g] <= 1'b0;
         else if (set_i[g]) mode_o[g] <= 1'b1;
         else if (clr_i[g]) mode_o[g] <= 1'b0;
      end
   end

   a_r2_no_cmd_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (set_i == '0 && clr_i == '0) |=> $stable(mode_o));
   a_r3_set_takes: assert property (@(posedge clk) disable iff (!rst_n)
      set_i[MODE_EN] |=> mode_o[MODE_EN]);
   a_r4_clr_takes: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i[MODE_WT] |=> !mode_o[MODE_WT]);
endmodule

// File: rtl/dcc_err.sv
module dcc_err (
   input  logic clk,
   input  logic rst_n,
   input  logic err_set_i,
   input  logic rd_en_i,
   output logic flag_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         flag_o <= 1'b0;
      else if (err_set_i) flag_o <= 1'b1;
      else if (rd_en_i)   flag_o <= 1'b0;
   end

   a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_o && !rd_en_i) |=> flag_o);
   a_r9_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en_i && !err_set_i) |=> !flag_o);
   a_r10_not_lost: assert property (@(posedge clk) disable iff (!rst_n)
      err_set_i |=> flag_o);
endmodule

// File: rtl/dcc_req.sv
module dcc_req
   import dcc_pkg::*;
#(
   parameter int ADDR_W  = 32,
   parameter bit REQ_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              blk_i,
   input  logic [CMD_W-1:0]  cmd_i,
   input  logic [ADDR_W-1:0] addr_i,
   output logic              valid_o,
   output logic [CMD_W-1:0]  cmd_o,
   output logic [ADDR_W-1:0] addr_o
);
   if (REQ_REG) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            valid_o <= 1'b0;
            cmd_o   <= '0;
            addr_o  <= '0;
         end else begin
            valid_o <= blk_i;
            if (blk_i) begin
               cmd_o  <= cmd_i;
               addr_o <= addr_i;
            end
         end
      end

      a_r6_from_cmd: assert property (@(posedge clk) disable iff (!rst_n)
         valid_o |-> $past(blk_i));
      a_r6_even_code: assert property (@(posedge clk) disable iff (!rst_n)
         valid_o |-> (cmd_o[0] == 1'b0 && cmd_o != 4'h0));
   end else begin : g_comb
      assign valid_o = blk_i;
      assign cmd_o   = blk_i ? cmd_i  : '0;
      assign addr_o  = blk_i ? addr_i : '0;
   end
endmodule

// File: rtl/dcache_ctl_reg.sv
module dcache_ctl_reg
   import dcc_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter int ADDR_W  = 32,
   parameter bit REQ_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic              rd_en_i,
   output logic [DATA_W-1:0] rdata_o,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              busy_i,
   input  logic              err_set_i,
   output logic              cache_en_o,
   output logic              force_wt_o,
   output logic              le_swap_o,
   output logic              maint_valid_o,
   output logic [3:0]        maint_cmd_o,
   output logic [ADDR_W-1:0] maint_addr_o,
   output logic              mchk_o
);
   localparam int POS_EN  = msb0(DATA_W, 0);
   localparam int POS_WT  = msb0(DATA_W, 1);
   localparam int POS_LE  = msb0(DATA_W, 2);
   localparam int POS_CMD = msb0(DATA_W, 4);
   localparam int POS_ERR = msb0(DATA_W, 10);

   if (DATA_W < 11) begin : g_chk_dw
      $error("dcache_ctl_reg: DATA_W must reach register bit 10");
   end
   if (ADDR_W < 1) begin : g_chk_aw
      $error("dcache_ctl_reg: ADDR_W must be positive");
   end

   logic             cmd_vld;
   logic [CMD_W-1:0] cmd;
   dcc_dec_t         dec;
   logic [MODE_N-1:0] mode;
   logic             err_flag;

   assign cmd_vld = wr_en_i && !busy_i;
   assign cmd     = wdata_i[POS_CMD -: CMD_W];

   dcc_decode u_dec (
      .cmd_vld_i (cmd_vld),
      .cmd_i     (cmd),
      .dec_o     (dec)
   );

   dcc_status u_status (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (dec.set),
      .clr_i  (dec.clr),
      .mode_o (mode)
   );

   dcc_err u_err (
      .clk       (clk),
      .rst_n     (rst_n),
      .err_set_i (err_set_i),
      .rd_en_i   (rd_en_i),
      .flag_o    (err_flag)
   );

   dcc_req #(.ADDR_W(ADDR_W), .REQ_REG(REQ_REG)) u_req (
      .clk     (clk),
      .rst_n   (rst_n),
      .blk_i   (dec.blk),
      .cmd_i   (cmd),
      .addr_i  (addr_i),
      .valid_o (maint_valid_o),
      .cmd_o   (maint_cmd_o),
      .addr_o  (maint_addr_o)
   );

   assign cache_en_o = mode[MODE_EN];
   assign force_wt_o = mode[MODE_WT];
   assign le_swap_o  = mode[MODE_LE];
   assign mchk_o     = err_flag;

   always_comb begin
      rdata_o          = '0;
      rdata_o[POS_EN]  = mode[MODE_EN];
      rdata_o[POS_WT]  = mode[MODE_WT];
      rdata_o[POS_LE]  = mode[MODE_LE];
      rdata_o[POS_ERR] = err_flag;
   end

   if (REQ_REG) begin : g_busy_chk
      a_r11_busy_drops: assert property (@(posedge clk) disable iff (!rst_n)
         (busy_i && wr_en_i) |=> (!maint_valid_o && $stable(mode)));
   end
   a_r8_cmd_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
      rdata_o[POS_CMD -: CMD_W] == '0);
   a_r9_mchk_follows: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mchk_o) |-> $past(err_set_i));
endmodule

// File: tb/dcache_ctl_reg_bench.sv
`timescale 1ns/1ps
module dcache_ctl_reg_bench;
   localparam int DW = 32;
   localparam int AW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0, rd_en = 1'b0, busy = 1'b0, err_set = 1'b0;
   logic [DW-1:0] wdata = '0;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] rdata;
   logic          en_o, wt_o, le_o, mv_o, mchk;
   logic [3:0]    mcmd;
   logic [AW-1:0] maddr;

   int total = 0;
   int bad   = 0;

   always #4 clk = ~clk;

   dcache_ctl_reg u_dcache_ctl_reg (
      .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wdata_i(wdata),
      .rd_en_i(rd_en), .rdata_o(rdata), .addr_i(addr), .busy_i(busy),
      .err_set_i(err_set), .cache_en_o(en_o), .force_wt_o(wt_o),
      .le_swap_o(le_o), .maint_valid_o(mv_o), .maint_cmd_o(mcmd),
      .maint_addr_o(maddr), .mchk_o(mchk)
   );

   // behavioural reference model
   bit          m_en, m_wt, m_le, m_err, m_v;
   bit [3:0]    m_cmd;
   bit [AW-1:0] m_addr;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_en = 0; m_wt = 0; m_le = 0; m_err = 0; m_v = 0;
      end else begin
         bit [3:0] c;
         c = wdata[27:24];
         m_v = 0;
         if (wr_en && !busy) begin
            case (c)
               4'h2: m_en = 1;  4'h4: m_en = 0;
               4'h1: m_wt = 1;  4'h3: m_wt = 0;
               4'h5: m_le = 1;  4'h7: m_le = 0;
               4'h6, 4'h8, 4'hA, 4'hC, 4'hE: begin
                  m_v = 1; m_cmd = c; m_addr = addr;
               end
               default: ;
            endcase
         end
         if (err_set)    m_err = 1;
         else if (rd_en) m_err = 0;
      end
   end

   task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic logic [DW-1:0] exp_rd();
      logic [DW-1:0] r;
      r = '0;
      r[31] = m_en; r[30] = m_wt; r[29] = m_le; r[21] = m_err;
      return r;
   endfunction

   always @(negedge clk) begin
      if (rst_n) begin
         chk("R3 enable", {31'b0, en_o}, {31'b0, m_en});
         chk("R4 write-through", {31'b0, wt_o}, {31'b0, m_wt});
         chk("R5 swap", {31'b0, le_o}, {31'b0, m_le});
         chk("R8 rdata", rdata, exp_rd());
         chk("R9 mchk", {31'b0, mchk}, {31'b0, m_err});
         chk("R6 valid", {31'b0, mv_o}, {31'b0, m_v});
         if (m_v) begin
            chk("R6 cmd", {28'b0, mcmd}, {28'b0, m_cmd});
            chk("R6 addr", maddr, m_addr);
         end
      end
   end

   // one cycle: drive at the falling edge, hold across the rising edge
   task automatic cyc(input bit w, input logic [3:0] c, input logic [DW-1:0] other,
                      input bit r, input bit e, input bit b, input logic [AW-1:0] a);
      wr_en = w; rd_en = r; err_set = e; busy = b; addr = a;
      wdata = other; wdata[27:24] = c;
      @(posedge clk);
      @(negedge clk);
      wr_en = 0; rd_en = 0; err_set = 0; busy = 0;
   endtask

   initial begin
      #(200000 * 8);
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R1 reset rdata", rdata, '0);
      chk("R1 reset outs", {27'b0, en_o, wt_o, le_o, mv_o, mchk}, '0);
      rst_n = 1'b1;
      // R2, R7: ones on the mode bits with a reserved code
      cyc(1, 4'h0, 32'hFFFF_FFFF, 0, 0, 0, 32'h10);
      chk("R2 direct write ignored", rdata, '0);
      cyc(1, 4'hF, 32'hE000_0000, 0, 0, 0, 32'h10);
      chk("R7 reserved code no action", {30'b0, en_o, mv_o}, '0);
      cyc(1, 4'h2, 32'h0, 0, 0, 0, 0);
      chk("R3 enable set", {31'b0, en_o}, 32'd1);
      cyc(1, 4'h1, 32'h0, 0, 0, 0, 0);
      cyc(1, 4'h5, 32'h0, 0, 0, 0, 0);
      chk("R8 layout", rdata, 32'hE000_0000);
      cyc(1, 4'h4, 32'hFFFF_FFFF, 0, 0, 0, 0);
      chk("R2 clear with ones elsewhere", rdata, 32'h6000_0000);
      cyc(1, 4'hE, 32'h0, 0, 0, 0, 32'hCAFE_0040);
      chk("R6 flush pulse", {mv_o, 27'b0, mcmd}, {1'b1, 27'b0, 4'hE});
      chk("R6 flush addr", maddr, 32'hCAFE_0040);
      cyc(0, 4'h0, 32'h0, 0, 0, 0, 0);
      chk("R6 single cycle", {31'b0, mv_o}, '0);
      cyc(1, 4'hC, 32'h0, 0, 0, 1, 0);
      chk("R11 busy drops", {31'b0, mv_o}, '0);
      cyc(1, 4'h3, 32'h0, 0, 0, 1, 0);
      chk("R11 busy mode kept", {31'b0, wt_o}, 32'd1);
      cyc(0, 4'h0, 32'h0, 0, 1, 0, 0);
      chk("R9 error set", {31'b0, mchk}, 32'd1);
      cyc(0, 4'h0, 32'h0, 0, 0, 0, 0);
      chk("R9 sticky", {31'b0, rdata[21]}, 32'd1);
      cyc(0, 4'h0, 32'h0, 1, 1, 0, 0);
      chk("R10 read plus error keeps flag", {31'b0, mchk}, 32'd1);
      cyc(0, 4'h0, 32'h0, 1, 0, 0, 0);
      chk("R9 read clears", {31'b0, mchk}, '0);
      // back-to-back maintenance commands
      for (int k = 0; k < 5; k++) begin
         cyc(1, 4'(6 + 2 * k), 32'h0, 0, 0, 0, 32'(k * 64));
      end
      // random traffic checked against the model every cycle
      for (int i = 0; i < 3000; i++) begin
         cyc(($urandom % 3) != 0, 4'($urandom), $urandom, ($urandom % 4) == 0,
             ($urandom % 8) == 0, ($urandom % 5) == 0, $urandom);
      end
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule